// File: doc/BRIEF.md
# Calibrated Fractional Seconds Prescaler

The block divides a crystal tick enable of roughly 33.33 kHz into a one-second strobe. The period comes from a stored calibration word. That word holds a whole tick count for one second and an optional fractional trim. When the trim is switched on, it stretches some seconds of a sixteen-second cycle by one extra tick, which corrects long-term drift of a crystal whose frequency is not an integer number of hertz. The live tick count is brought out for readback so that software can find the phase inside the current second.

A calibration write pulse stores a new word and restarts the count. Both the tick counter and the sixteen-second index return to zero, so the next strobe arrives exactly one full second period after the write. The block sits between a register decoder and the seconds/time-of-day logic. It contains neither of those.

Top module: `sec_prescaler`

## Requirements
- R1: After reset, the stored calibration word reads 0x198233, the tick count is 0 and the second strobe is low.
- R2: A cycle with `cal_wr` high stores bits 20:0 of `cal_wdata`. Bits above bit 20 are ignored, and `cal_rdata` returns the stored 21-bit word from the next cycle onward.
- R3: The tick count advances by one only in cycles with `tick_en` high. Without `tick_en` or a write, it holds its value.
- R4: With the fraction enable (bit 20) clear, every second lasts T ticks, where T is bits 15:0.
- R5: With bit 20 set and N taken from bits 19:16, the seconds whose index in the repeating sixteen-second cycle is below N last T+1 ticks. The remaining seconds last T ticks.
- R6: A calibration write clears the tick count and the second index. If a tick arrives in the same cycle as the write, the write wins and no strobe is produced.
- R7: `sec_strobe` is high for exactly one clock, in the cycle after the tick that completes a second. In that same cycle the tick count reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per crystal tick |
| cal_wr | input | 1 | Calibration write strobe |
| cal_wdata | input | 32 | Calibration write data; bits above bit 20 are ignored |
| cal_rdata | output | 21 | Stored calibration word |
| tick_count | output | 16 | Live tick count within the current second |
| sec_strobe | output | 1 | One-cycle pulse at the end of each second |

## Verification
The bench builds the block with its default widths and the default word 0x198233. This lets it observe one full default-length second of 33332 ticks, where index 0 is stretched by the trim of 9. Short programmed words such as T=2 or T=3 with fractions of 1 and 15 bring a whole sixteen-second trim cycle, and its wrap back to index 0, within a few dozen ticks. These short words also allow phase restarts and a write that collides with a tick to be placed on exact tick positions.

// File: rtl/sp_pkg.sv
package sp_pkg;
   // Default geometry of the calibration word
   localparam int SP_CNT_W  = 16;
   localparam int SP_FRAC_W = 4;
   localparam int SP_BUS_W  = 32;
   localparam logic [31:0] SP_CAL_DEFAULT = 32'h0019_8233;

   // A second is stretched when its index lies below the trim value
   function automatic logic sp_stretch(input logic en,
                                       input logic [SP_FRAC_W-1:0] idx,
                                       input logic [SP_FRAC_W-1:0] trim);
      return en && (idx < trim);
   endfunction
endpackage

// File: rtl/sp_cal_reg.sv
module sp_cal_reg #(
   parameter int          CNT_W       = 16,
   parameter int          FRAC_W      = 4,
   parameter int          BUS_W       = 32,
   parameter logic [31:0] CAL_DEFAULT = 32'h0019_8233,
   localparam int         CAL_W       = CNT_W + FRAC_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [BUS_W-1:0] wdata,
   output logic [CAL_W-1:0] word
);
   if (BUS_W < CAL_W) begin : g_bus_chk
      $error("sp_cal_reg: bus narrower than calibration word");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   word <= CAL_DEFAULT[CAL_W-1:0];
      else if (wr)  word <= wdata[CAL_W-1:0];
   end
endmodule

// File: rtl/sp_frac_seq.sv
module sp_frac_seq #(
   parameter int FRAC_W      = 4,
   parameter bit FRAC_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic              en,
   input  logic [FRAC_W-1:0] trim,
   output logic              stretch
);
   if (FRAC_W < 1) begin : g_w_chk
      $error("sp_frac_seq: FRAC_W must be at least 1");
   end

   if (FRAC_ENABLE) begin : g_trim
      logic [FRAC_W-1:0] idx;
      always_ff @(posedge clk) begin
         if (!rst_n || clear) idx <= '0;
         else if (advance)    idx <= idx + 1'b1;
      end
      assign stretch = en && (idx < trim);
   end else begin : g_no_trim
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, clear, advance, en, trim};
      assign stretch = 1'b0;
   end
endmodule

// File: rtl/sp_tick_ctr.sv
module sp_tick_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  logic [CNT_W-1:0] period,
   input  logic             stretch,
   output logic [CNT_W-1:0] count,
   output logic             strobe,
   output logic             wrap_evt
);
   localparam int EXT_W = CNT_W + 1;

   if (CNT_W < 2) begin : g_w_chk
      $error("sp_tick_ctr: CNT_W must be at least 2");
   end

   logic [EXT_W-1:0] next_cnt;
   logic [EXT_W-1:0] limit;

   always_comb begin
      next_cnt = {1'b0, count} + 1'b1;
      limit    = {1'b0, period} + {{CNT_W{1'b0}}, stretch};
      wrap_evt = tick && !clear && (next_cnt >= limit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         count  <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= wrap_evt;
         if (wrap_evt)  count <= '0;
         else if (tick) count <= next_cnt[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
   parameter int          CNT_W       = sp_pkg::SP_CNT_W,
   parameter int          FRAC_W      = sp_pkg::SP_FRAC_W,
   parameter int          BUS_W       = sp_pkg::SP_BUS_W,
   parameter bit          FRAC_ENABLE = 1'b1,
   parameter logic [31:0] CAL_DEFAULT = sp_pkg::SP_CAL_DEFAULT,
   localparam int         CAL_W       = CNT_W + FRAC_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cal_wr,
   input  logic [BUS_W-1:0] cal_wdata,
   output logic [CAL_W-1:0] cal_rdata,
   output logic [CNT_W-1:0] tick_count,
   output logic             sec_strobe
);
   localparam int EN_BIT = CNT_W + FRAC_W;

   logic [CAL_W-1:0] word;
   logic             stretch;
   logic             wrap_evt;

   sp_cal_reg #(
      .CNT_W(CNT_W), .FRAC_W(FRAC_W), .BUS_W(BUS_W), .CAL_DEFAULT(CAL_DEFAULT)
   ) u_cal (
      .clk(clk), .rst_n(rst_n), .wr(cal_wr), .wdata(cal_wdata), .word(word)
   );

   sp_frac_seq #(.FRAC_W(FRAC_W), .FRAC_ENABLE(FRAC_ENABLE)) u_frac (
      .clk(clk), .rst_n(rst_n), .clear(cal_wr), .advance(wrap_evt),
      .en(word[EN_BIT]), .trim(word[EN_BIT-1:CNT_W]), .stretch(stretch)
   );

   sp_tick_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .clear(cal_wr),
      .period(word[CNT_W-1:0]), .stretch(stretch),
      .count(tick_count), .strobe(sec_strobe), .wrap_evt(wrap_evt)
   );

   assign cal_rdata = word;
endmodule

// File: rtl/sec_prescaler_chk.sv
module sec_prescaler_chk #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 32,
   parameter int CAL_W = 21
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             cal_wr,
   input logic [BUS_W-1:0] cal_wdata,
   input logic [CAL_W-1:0] cal_rdata,
   input logic [CNT_W-1:0] tick_count,
   input logic             sec_strobe
);
   a_r2_store_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      cal_wr |=> cal_rdata == $past(cal_wdata[CAL_W-1:0]));

   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cal_wr) |=> $stable(tick_count));

   a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cal_wr) |=>
         ((tick_count == $past(tick_count) + 1'b1) || (tick_count == '0 && sec_strobe)));

   a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cal_wr |=> (tick_count == '0 && !sec_strobe));

   a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sec_strobe |-> ($past(tick_en) && !$past(cal_wr)));

   a_r7_strobe_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sec_strobe |-> tick_count == '0);
endmodule

bind sec_prescaler sec_prescaler_chk #(
   .CNT_W(CNT_W), .BUS_W(BUS_W), .CAL_W(CAL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cal_wr(cal_wr),
   .cal_wdata(cal_wdata), .cal_rdata(cal_rdata),
   .tick_count(tick_count), .sec_strobe(sec_strobe)
);

// File: tb/sec_prescaler_tb.sv
module sec_prescaler_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   typedef struct packed {
      logic [31:0] word;
      logic [31:0] ticks;
      logic [31:0] strobes;
      logic [31:0] cnt;
      logic [31:0] rb;
   } vec_t;

   // word, ticks applied after the write, strobes expected, final count, readback
   localparam vec_t VECS [6] = '{
      '{32'h0003_0005, 32'd23, 32'd4,  32'd3, 32'h0003_0005},  // R4 fraction off
      '{32'h0013_0005, 32'd23, 32'd4,  32'd0, 32'h0013_0005},  // R5 N=3
      '{32'h001F_0003, 32'd70, 32'd17, 32'd3, 32'h001F_0003},  // R5 N=15 wrap
      '{32'h0010_0004, 32'd17, 32'd4,  32'd1, 32'h0010_0004},  // R5 N=0
      '{32'hFFE0_0006, 32'd13, 32'd2,  32'd1, 32'h0000_0006},  // R2 high bits ignored
      '{32'h0011_0002, 32'd40, 32'd19, 32'd0, 32'h0011_0002}   // R5 N=1 wrap
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        cal_wr = 1'b0;
   logic [31:0] cal_wdata = '0;
   logic [20:0] cal_rdata;
   logic [15:0] tick_count;
   logic        sec_strobe;

   int n_chk = 0;
   int n_bad = 0;
   int strobes = 0;
   bit done = 1'b0;

   sec_prescaler u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cal_wr(cal_wr),
      .cal_wdata(cal_wdata), .cal_rdata(cal_rdata),
      .tick_count(tick_count), .sec_strobe(sec_strobe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_tick();
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      if (sec_strobe) strobes++;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) do_tick();
   endtask

   task automatic write_cal(input logic [31:0] w);
      @(negedge clk) begin cal_wr = 1'b1; cal_wdata = w; end
      @(negedge clk) cal_wr = 1'b0;
      strobes = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 readback", {11'b0, cal_rdata}, 32'h0019_8233);
      check("R1 count", {16'b0, tick_count}, 32'd0);
      check("R1 strobe", {31'b0, sec_strobe}, 32'd0);

      // R5 default word: index 0 stretched, 33331+1 ticks
      strobes = 0;
      ticks(33331);
      check("R5 default no early strobe", strobes, 32'd0);
      check("R5 default count", {16'b0, tick_count}, 32'd33331);
      ticks(1);
      check("R5 default strobe at 33332", strobes, 32'd1);
      check("R7 count zero after second", {16'b0, tick_count}, 32'd0);

      foreach (VECS[k]) begin
         write_cal(VECS[k].word);
         check("R2 vector readback", {11'b0, cal_rdata}, VECS[k].rb);
         ticks(int'(VECS[k].ticks));
         check("R4 R5 vector strobes", strobes, VECS[k].strobes);
         check("R4 R5 vector count", {16'b0, tick_count}, VECS[k].cnt);
      end

      // R3 hold without tick
      write_cal(32'h0000_0005);
      ticks(2);
      repeat (5) @(negedge clk);
      check("R3 hold count", {16'b0, tick_count}, 32'd2);

      // R6 rewrite restarts phase
      ticks(1);
      write_cal(32'h0000_0005);
      check("R6 count cleared", {16'b0, tick_count}, 32'd0);
      ticks(4);
      check("R6 no strobe before full period", strobes, 32'd0);
      ticks(1);
      check("R6 strobe one period after write", strobes, 32'd1);

      // R6 fraction index restarts: second 0 long again after rewrite
      write_cal(32'h0013_0005);
      ticks(6);
      write_cal(32'h0013_0005);
      ticks(5);
      check("R6 index restart no strobe at 5", strobes, 32'd0);
      ticks(1);
      check("R6 index restart strobe at 6", strobes, 32'd1);

      // R6 write collides with a completing tick
      write_cal(32'h0000_0005);
      ticks(4);
      @(negedge clk) begin tick_en = 1'b1; cal_wr = 1'b1; cal_wdata = 32'h0000_0005; end
      @(negedge clk) begin tick_en = 1'b0; cal_wr = 1'b0; end
      check("R6 collision no strobe", {31'b0, sec_strobe}, 32'd0);
      check("R6 collision count", {16'b0, tick_count}, 32'd0);

      // R7 strobe lasts one clock: with ticks every cycle at T=3
      write_cal(32'h0000_0003);
      @(negedge clk) tick_en = 1'b1;
      repeat (3) @(negedge clk);
      tick_en = 1'b0;
      check("R7 strobe high after third tick", {31'b0, sec_strobe}, 32'd1);
      @(negedge clk);
      check("R7 strobe single cycle", {31'b0, sec_strobe}, 32'd0);

      // R1 reset mid-run restores default
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset readback", {11'b0, cal_rdata}, 32'h0019_8233);
      check("R1 reset count", {16'b0, tick_count}, 32'd0);

      finish_run();
   end
endmodule